// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block generates the system reset for a small microcontroller. It takes a digital supply-good level from an external comparator and holds an active-low reset output asserted while the supply is below threshold. After the supply recovers, it keeps reset asserted until a stabilisation timeout has run. A power-on status flag tells software whether the last reset came from the supply path. Software can also start the same supply-style sequence through a one-bit register write.

Resets from any other source arrive as a pulse. Such a pulse asserts the output for a short fixed minimum, skips the long timeout, and clears the status flag. The supply-good input is asynchronous and passes through a two-stage synchroniser. A single shared counter times both the long and the short hold.

Top module: `por_seq`

## Requirements
- R1: While `supply_ok_i` is low, `rst_no` stays 0. This holds at first power-up and during any later drop.
- R2: After `supply_ok_i` goes high, `rst_no` rises on the (TIMEOUT_CYC+3)th rising clock edge. The count is two synchroniser stages, one state step and TIMEOUT_CYC timeout cycles.
- R3: When `rst_no` is released after a supply-caused or software-forced sequence, `por_flag_o` becomes 1 on the same edge.
- R4: If `supply_ok_i` falls while running, `rst_no` falls on the 3rd rising edge after the drop. Recovery then follows R2.
- R5: An `ext_rst_i` pulse while running drives `rst_no` low on the next edge and releases it MIN_PULSE_CYC edges later. `por_flag_o` becomes 0 at that release.
- R6: A write with `sw_we_i`=1 and `sw_wdata_i`=1 while running drives `rst_no` low on the next edge. `rst_no` rises TIMEOUT_CYC edges after that, with `por_flag_o`=1.
- R7: A write with `sw_wdata_i`=0 has no effect: `rst_no` stays 1 and `por_flag_o` keeps its value.
- R8: If the supply drops during the timeout, the count restarts from zero. Release is then TIMEOUT_CYC+3 edges after the final recovery.
- R9: An `ext_rst_i` pulse during the short hold restarts it. Release comes MIN_PULSE_CYC edges after the edge that sampled the last pulse.
- R10: `ext_rst_i` is ignored during the long timeout: release time and a flag value of 1 are unchanged. A forcing write and `ext_rst_i` arriving in the same cycle start the long sequence.
- R11: While `rst_ni` is low, `rst_no` is 0 and `por_flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | free-running clock |
| rst_ni | input | 1 | asynchronous active-low reset of the sequencer itself |
| supply_ok_i | input | 1 | asynchronous supply-above-threshold level |
| ext_rst_i | input | 1 | one-cycle reset request from another source |
| sw_we_i | input | 1 | software write strobe for the flag bit |
| sw_wdata_i | input | 1 | value written to the flag bit; 1 forces a power-on sequence |
| rst_no | output | 1 | active-low system reset |
| por_flag_o | output | 1 | power-on status flag |

## Verification
The bench builds the block with TIMEOUT_CYC=6 and MIN_PULSE_CYC=3. With these values every release edge can be counted exactly. The short timeout also makes it possible to sweep a supply drop into every cycle of the timeout window and an extra pulse into every cycle of the short hold. The same values expose the sync latency and the arbitration between the long and short holds at cycle resolution.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic [1:0] {
    ST_LOW   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_PULSE = 2'd2,
    ST_RUN   = 2'd3
  } por_st_e;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/por_timer.sv
module por_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == last_i);
endmodule

// File: rtl/por_seq.sv
module por_seq #(
  parameter int TIMEOUT_CYC   = 25_000_000,
  parameter int MIN_PULSE_CYC = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic ext_rst_i,
  input  logic sw_we_i,
  input  logic sw_wdata_i,
  output logic rst_no,
  output logic por_flag_o
);
  import por_pkg::*;

  localparam int MAX_CYC = (TIMEOUT_CYC > MIN_PULSE_CYC) ? TIMEOUT_CYC : MIN_PULSE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TO_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] PL_LAST = CNT_W'(MIN_PULSE_CYC - 1);

  por_st_e st_q, st_d;
  logic sup_s, flag_q, flag_d, rst_q;
  logic t_clr, t_en, t_done;
  logic [CNT_W-1:0] t_last;

  por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (supply_ok_i),
    .q_o   (sup_s)
  );

  // one counter shared by both holds; limit picked by state
  assign t_last = (st_q == ST_WAIT) ? TO_LAST : PL_LAST;

  por_timer #(.W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (t_clr),
    .en_i  (t_en),
    .last_i(t_last),
    .done_o(t_done)
  );

  always_comb begin
    st_d   = st_q;
    flag_d = flag_q;
    t_clr  = 1'b0;
    t_en   = 1'b0;
    if (!sup_s) begin
      st_d  = ST_LOW;
      t_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_LOW: begin
          st_d  = ST_WAIT;
          t_clr = 1'b1;
        end
        ST_WAIT: begin
          t_en = 1'b1;
          if (t_done) begin
            st_d   = ST_RUN;
            flag_d = 1'b1;
            t_clr  = 1'b1;
          end
        end
        ST_PULSE: begin
          if (ext_rst_i) begin
            t_clr = 1'b1;
          end else begin
            t_en = 1'b1;
            if (t_done) begin
              st_d   = ST_RUN;
              flag_d = 1'b0;
              t_clr  = 1'b1;
            end
          end
        end
        ST_RUN: begin
          // forced power-on outranks other-source reset
          if (sw_we_i && sw_wdata_i) begin
            st_d  = ST_WAIT;
            t_clr = 1'b1;
          end else if (ext_rst_i) begin
            st_d  = ST_PULSE;
            t_clr = 1'b1;
          end
        end
        default: st_d = ST_LOW;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LOW;
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
      rst_q  <= (st_d == ST_RUN);
    end
  end

  assign rst_no     = rst_q;
  assign por_flag_o = flag_q;
endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sup_s,
  input logic ext_rst_i,
  input logic sw_we_i,
  input logic sw_wdata_i,
  input logic rst_no,
  input logic por_flag_o
);
  a_r1_low_supply_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_s |=> !rst_no);

  a_r3_flag_set_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(por_flag_o) |-> $rose(rst_no));

  a_r5_flag_clear_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_flag_o) |-> $rose(rst_no));

  a_r5_ext_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no && ext_rst_i |=> !rst_no);

  a_r6_force_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no && sw_we_i && sw_wdata_i |=> !rst_no);

  a_r7_zero_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_no && sup_s && sw_we_i && !sw_wdata_i && !ext_rst_i |=> rst_no && $stable(por_flag_o));
endmodule

bind por_seq por_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sup_s     (sup_s),
  .ext_rst_i (ext_rst_i),
  .sw_we_i   (sw_we_i),
  .sw_wdata_i(sw_wdata_i),
  .rst_no    (rst_no),
  .por_flag_o(por_flag_o)
);

// File: tb/tb_por_seq.sv
module tb_por_seq;
  localparam int T = 6;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0, ext_rst = 1'b0, sw_we = 1'b0, sw_wdata = 1'b0;
  logic rst_n, por_flag;
  int total = 0, bad = 0;
  int k;

  always #2 clk = ~clk;

  por_seq #(.TIMEOUT_CYC(T), .MIN_PULSE_CYC(P), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .ext_rst_i(ext_rst),
    .sw_we_i(sw_we), .sw_wdata_i(sw_wdata), .rst_no(rst_n), .por_flag_o(por_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts negedges from 'start' until rst_n high
  task automatic wait_rise(input int start, output int kk);
    kk = start;
    while (!rst_n && kk < 200) begin
      @(negedge clk);
      kk++;
    end
  endtask

  task automatic wait_fall(output int kk);
    kk = 0;
    while (rst_n && kk < 200) begin
      @(negedge clk);
      kk++;
    end
  endtask

  task automatic ext_pulse();
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
  endtask

  task automatic sw_write(input logic v);
    sw_we = 1'b1; sw_wdata = v;
    @(negedge clk);
    sw_we = 1'b0; sw_wdata = 1'b0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R11 rst_no in reset", rst_n, 0);
    chk("R11 flag in reset", por_flag, 0);
    rst_ni = 1'b1;
    cyc(40);
    chk("R1 held while supply low", rst_n, 0);

    supply_ok = 1'b1;
    wait_rise(0, k);
    chk("R2 power-up release edge", k, T + 3);
    chk("R3 flag after power-up", por_flag, 1);

    ext_pulse();
    chk("R5 ext asserts next edge", rst_n, 0);
    wait_rise(1, k);
    chk("R5 ext release edge", k, P + 1);
    chk("R5 flag cleared", por_flag, 0);

    sw_write(1'b1);
    chk("R6 force asserts next edge", rst_n, 0);
    wait_rise(1, k);
    chk("R6 force release edge", k, T + 1);
    chk("R3 R6 flag after forced sequence", por_flag, 1);

    for (int i = 0; i < 4; i++) begin
      sw_write(1'b0);
      cyc(3);
      chk("R7 zero write rst_no", rst_n, 1);
      chk("R7 zero write flag", por_flag, 1);
    end
    ext_pulse();
    wait_rise(1, k);
    sw_write(1'b0);
    cyc(3);
    chk("R7 zero write keeps flag 0", por_flag, 0);
    chk("R7 zero write rst_no stays", rst_n, 1);

    supply_ok = 1'b0;
    wait_fall(k);
    chk("R4 brown-out fall edge", k, 3);
    cyc(10);
    chk("R1 held during brown-out", rst_n, 0);
    supply_ok = 1'b1;
    wait_rise(0, k);
    chk("R4 brown-out recovery edge", k, T + 3);
    chk("R3 flag after brown-out", por_flag, 1);

    // supply drop at every cycle of the timeout window
    for (int d = 1; d <= T; d++) begin
      supply_ok = 1'b0;
      cyc(6);
      supply_ok = 1'b1;
      cyc(d);
      chk("R8 still held before drop", rst_n, 0);
      supply_ok = 1'b0;
      cyc(2);
      supply_ok = 1'b1;
      wait_rise(0, k);
      chk("R8 restart from final recovery", k, T + 3);
    end

    // extra pulse at every cycle of the short hold
    for (int d = 1; d <= P - 1; d++) begin
      ext_pulse();
      cyc(d - 1);
      chk("R9 held before extra pulse", rst_n, 0);
      ext_pulse();
      wait_rise(1, k);
      chk("R9 short hold restart", k, P + 1);
      chk("R9 flag cleared", por_flag, 0);
    end

    // ext during long timeout ignored
    for (int d = 1; d <= T - 1; d++) begin
      sw_write(1'b1);
      cyc(d - 1);
      ext_pulse();
      wait_rise(d + 1, k);
      chk("R10 ext ignored in timeout", k, T + 1);
      chk("R10 flag stays set", por_flag, 1);
      ext_pulse();
      wait_rise(1, k);
    end

    // simultaneous force and ext: long sequence wins
    sw_we = 1'b1; sw_wdata = 1'b1; ext_rst = 1'b1;
    @(negedge clk);
    sw_we = 1'b0; sw_wdata = 1'b0; ext_rst = 1'b0;
    wait_rise(1, k);
    chk("R10 force beats ext", k, T + 1);
    chk("R10 flag after tie", por_flag, 1);

    rst_ni = 1'b0;
    cyc(1);
    chk("R11 async reset rst_no", rst_n, 0);
    chk("R11 async reset flag", por_flag, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule